// File: doc/BRIEF.md
# Tape Speed Servo Pulse-Width Generator

This block produces the pulse-width-modulated SPEED drive for a tape capstan. Each reference frame tick closes an update window. At that tick the block turns the measured position of the incoming tape frame into an 8-bit duty code. The position is the signed distance, in clock cycles, from the reference tick to the first incoming frame strobe of the window. Depending on the control bits, the block may add a frequency correction taken from the bit count measured over the window. A host-written duty value can replace the whole computation. An 8-bit free-running counter then turns the active duty code into a pulse.

The phase term wraps modulo 256, so a phase error beyond the valid span gives a saw-tooth response. The frequency correction steers the tape back toward the nominal rate. Depending on the mode, it applies at full weight beyond a 6% deviation and at half weight in a 4.5% to 6% band. The summed code is clamped to 0..255. If no frame strobe arrived during a window, the previous code is held and a flag reports the missing measurement.

Top module: `tape_servo_pwm`

## Requirements
- R1: While reset is asserted and directly after it, duty_o is 128 and phase_miss_o is 0. The PWM counter starts at 0 with an active duty of 128, so speed_o is high.
- R2: In phase-only mode, the update at a reference tick sets duty_o to (128 + floor(e / 2^PH_SHIFT)) mod 256. Here e is the cycle count from the previous reference tick to the first frame strobe, read as a signed PH_W-bit value. A strobe in the same cycle as a reference tick counts as e = 0 for the window that tick opens.
- R3: The phase code wraps modulo 256 and is never clamped, so a large early or late error folds back into a saw-tooth.
- R4: Mode decode: host_spd_i = 1 selects host mode whatever the other bits are. Otherwise freq_en_i = 0 selects phase-only mode, and xfreq_en_i is then ignored. freq_en_i = 1 with xfreq_en_i = 0 selects tape frequency mode, and both set selects extended frequency mode.
- R5: In tape frequency mode, let dev = bit_cnt_i − NOM_CNT at the reference tick and TH_HI = floor(NOM_CNT·6/100). If |dev| > TH_HI, floor(−dev / 2^F_SHIFT) is added to the phase code. Otherwise the result is the phase code alone.
- R6: In extended frequency mode, let TH_LO = floor(NOM_CNT·45/1000). For |dev| ≤ TH_LO the result is the phase code alone. For TH_LO < |dev| ≤ TH_HI, floor(−dev / 2^(F_SHIFT+1)) is added. For |dev| > TH_HI, the full-weight term of R5 is added.
- R7: In host mode, the update loads host_duty_i into duty_o, whether or not a frame strobe was seen.
- R8: If a window held no frame strobe, the update in the other modes keeps duty_o unchanged. Every update sets phase_miss_o to 1 exactly when its window held no strobe.
- R9: duty_o changes only on the clock edge at which ref_tick_i is sampled high.
- R10: The PWM counter advances by one every cycle and wraps from 255 to 0. On the edge where the counter reads 255, the active duty is loaded from duty_o. speed_o is high while the counter is below the active duty (ACTIVE_HIGH = 1).
- R11: Only the first frame strobe of a window is measured. Later strobes in the same window have no effect.
- R12: A frequency-corrected sum below 0 gives 0 and a sum above 255 gives 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_stb_i | input | 1 | One-cycle strobe per incoming tape frame |
| ref_tick_i | input | 1 | One-cycle reference frame tick; closes a window and triggers the update |
| bit_cnt_i | input | CNT_W | Bit count measured over the closing window, sampled at the tick |
| freq_en_i | input | 1 | Frequency correction enable |
| xfreq_en_i | input | 1 | Extended (three-region) frequency enable |
| host_spd_i | input | 1 | Host duty override |
| host_duty_i | input | 8 | Host-written duty code |
| speed_o | output | 1 | PWM capstan drive |
| duty_o | output | 8 | Duty code from the last update |
| phase_miss_o | output | 1 | Last window held no frame strobe |

## Verification
The bench builds the block with PH_W = 10 and PH_SHIFT = 1, and drives a reference period of 1024 cycles. This period equals the span of the phase counter, so strobe offsets past half the window read as early. Offsets of a few hundred cycles push the phase code past both ends of the 8-bit range, which brings the saw-tooth wrap within reach. NOM_CNT = 2048 with F_SHIFT = 1 puts the band edges at deviations of 92 and 122 counts. The bench places bit counts exactly on and one count beyond each edge, in both directions, and drives sums past 0 and past 255 to reach the clamps.

// File: rtl/tsp_pkg.sv
package tsp_pkg;

   typedef enum logic [1:0] {
      MODE_PHASE = 2'd0,
      MODE_FREQ  = 2'd1,
      MODE_XFREQ = 2'd2,
      MODE_HOST  = 2'd3
   } servo_mode_e;

   typedef enum logic [1:0] {
      REG_INSIDE = 2'd0,
      REG_HALF   = 2'd1,
      REG_FULL   = 2'd2
   } freq_region_e;

   localparam logic [7:0] DUTY_MID = 8'd128;

endpackage

// File: rtl/tsp_phase_meter.sv
module tsp_phase_meter #(
   parameter int PH_W = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ref_tick,
   input  logic            frame_stb,
   output logic [PH_W-1:0] ph_err,
   output logic            ph_valid
);

   initial assert (PH_W >= 8) else $fatal(1, "PH_W must be at least 8");

   logic [PH_W-1:0] since_q;
   logic [PH_W-1:0] cap_q;
   logic            have_q;
   logic [PH_W-1:0] cur_pos;

   assign cur_pos = ref_tick ? '0 : since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_q <= '0;
         cap_q   <= '0;
         have_q  <= 1'b0;
      end else begin
         since_q <= ref_tick ? PH_W'(1) : since_q + PH_W'(1);
         if (ref_tick) begin
            have_q <= frame_stb;
            if (frame_stb) cap_q <= '0;
         end else if (frame_stb && !have_q) begin
            have_q <= 1'b1;
            cap_q  <= cur_pos;
         end
      end
   end

   assign ph_err   = cap_q;
   assign ph_valid = have_q;

   // R11: once a window holds a measurement, it stays until the next tick
   a_r11_first_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (have_q && !ref_tick) |=> $stable(cap_q));

   // R2: a strobe coincident with the tick measures zero for the new window
   a_r2_coincident_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_tick && frame_stb) |=> (have_q && cap_q == '0));

endmodule

// File: rtl/tsp_freq_region.sv
module tsp_freq_region
   import tsp_pkg::*;
#(
   parameter int CNT_W   = 12,
   parameter int NOM_CNT = 2048,
   parameter int F_SHIFT = 1,
   localparam int FT_W   = CNT_W + 2
) (
   input  logic [CNT_W-1:0]       bit_cnt,
   input  servo_mode_e            mode,
   output freq_region_e           region,
   output logic signed [FT_W-1:0] f_term
);

   localparam int TH_HI = (NOM_CNT * 6) / 100;
   localparam int TH_LO = (NOM_CNT * 45) / 1000;
   localparam logic signed [FT_W-1:0] NOM_S   = FT_W'(NOM_CNT);
   localparam logic signed [FT_W-1:0] TH_HI_S = FT_W'(TH_HI);
   localparam logic signed [FT_W-1:0] TH_LO_S = FT_W'(TH_LO);

   initial begin
      assert (NOM_CNT > 0 && NOM_CNT < (1 << CNT_W))
         else $fatal(1, "NOM_CNT must fit in CNT_W bits");
      assert (TH_LO < TH_HI) else $fatal(1, "band edges collapse");
      assert (F_SHIFT >= 0 && F_SHIFT + 1 < FT_W) else $fatal(1, "bad F_SHIFT");
   end

   logic signed [FT_W-1:0] dev;
   logic signed [FT_W-1:0] neg_dev;
   logic signed [FT_W-1:0] abs_dev;

   always_comb begin
      dev     = $signed({2'b00, bit_cnt}) - NOM_S;
      neg_dev = -dev;
      abs_dev = (dev < 0) ? neg_dev : dev;
      region  = REG_INSIDE;
      if (mode == MODE_FREQ) begin
         if (abs_dev > TH_HI_S) region = REG_FULL;
      end else if (mode == MODE_XFREQ) begin
         if (abs_dev > TH_HI_S)      region = REG_FULL;
         else if (abs_dev > TH_LO_S) region = REG_HALF;
      end
      case (region)
         REG_FULL: f_term = neg_dev >>> F_SHIFT;
         REG_HALF: f_term = neg_dev >>> (F_SHIFT + 1);
         default:  f_term = '0;
      endcase
   end

   // R6: the half-weight band exists only in extended frequency mode
   always_comb begin
      a_r6_half_only_ext: assert (!(region == REG_HALF && mode != MODE_XFREQ));
   end

endmodule

// File: rtl/tsp_duty_calc.sv
module tsp_duty_calc
   import tsp_pkg::*;
#(
   parameter int PH_W     = 14,
   parameter int PH_SHIFT = 5,
   parameter int FT_W     = 14,
   localparam int SUM_W   = FT_W + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ref_tick,
   input  servo_mode_e            mode,
   input  logic [PH_W-1:0]        ph_err,
   input  logic                   ph_valid,
   input  logic signed [FT_W-1:0] f_term,
   input  logic [7:0]             host_duty,
   output logic [7:0]             duty_q,
   output logic                   miss_q
);

   initial begin
      assert (PH_SHIFT >= 0 && PH_SHIFT < PH_W) else $fatal(1, "bad PH_SHIFT");
      assert (FT_W >= 9) else $fatal(1, "FT_W too small");
   end

   logic [7:0]              ph_lo;
   logic [7:0]              ph_duty;
   logic signed [SUM_W-1:0] sum;
   logic [7:0]              sum_clamped;
   logic [7:0]              nxt;
   logic                    load;

   always_comb begin
      ph_lo   = 8'($signed(ph_err) >>> PH_SHIFT);
      ph_duty = DUTY_MID + ph_lo;
      sum     = $signed({{(SUM_W-8){1'b0}}, ph_duty}) + SUM_W'(f_term);
      if (sum < 0)                          sum_clamped = 8'd0;
      else if (sum > $signed(SUM_W'(255)))  sum_clamped = 8'd255;
      else                                  sum_clamped = sum[7:0];
      case (mode)
         MODE_HOST:  nxt = host_duty;
         MODE_PHASE: nxt = ph_duty;
         default:    nxt = sum_clamped;
      endcase
      load = ref_tick && (mode == MODE_HOST || ph_valid);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_q <= DUTY_MID;
         miss_q <= 1'b0;
      end else begin
         if (load)     duty_q <= nxt;
         if (ref_tick) miss_q <= !ph_valid;
      end
   end

   // R9: the duty code moves only at an update
   a_r9_duty_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(duty_q) |-> $past(ref_tick));

   // R7: host mode loads the host code
   a_r7_host_load: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ref_tick) && $past(mode) == MODE_HOST) |-> duty_q == $past(host_duty));

   // R8: a window without a strobe holds the code outside host mode
   a_r8_hold_missing: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ref_tick) && !$past(ph_valid) && $past(mode) != MODE_HOST) |-> $stable(duty_q));

   // R8: the flag reflects the window just closed
   a_r8_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ref_tick) |-> (miss_q == !$past(ph_valid)));

endmodule

// File: rtl/tsp_pwm.sv
module tsp_pwm #(
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] duty,
   output logic       speed_o
);

   logic [7:0] cnt_q;
   logic [7:0] act_q;
   logic       below;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= 8'd0;
         act_q <= 8'd128;
      end else begin
         cnt_q <= cnt_q + 8'd1;
         if (cnt_q == 8'hFF) act_q <= duty;
      end
   end

   assign below = (cnt_q < act_q);

   generate
      if (ACTIVE_HIGH) begin : g_pol_hi
         assign speed_o = below;
      end else begin : g_pol_lo
         assign speed_o = !below;
      end
   endgenerate

   // R10: the active duty changes only at counter rollover
   a_r10_load_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_q) |-> $past(cnt_q) == 8'hFF);

   // R10: a zero active duty never drives the pulse
   a_r10_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q == 8'd0) |-> (speed_o == !ACTIVE_HIGH));

endmodule

// File: rtl/tape_servo_pwm.sv
module tape_servo_pwm
   import tsp_pkg::*;
#(
   parameter int PH_W        = 14,
   parameter int PH_SHIFT    = 5,
   parameter int CNT_W       = 12,
   parameter int NOM_CNT     = 2048,
   parameter int F_SHIFT     = 1,
   parameter bit ACTIVE_HIGH = 1'b1,
   localparam int FT_W       = CNT_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_stb_i,
   input  logic             ref_tick_i,
   input  logic [CNT_W-1:0] bit_cnt_i,
   input  logic             freq_en_i,
   input  logic             xfreq_en_i,
   input  logic             host_spd_i,
   input  logic [7:0]       host_duty_i,
   output logic             speed_o,
   output logic [7:0]       duty_o,
   output logic             phase_miss_o
);

   servo_mode_e            mode;
   freq_region_e           region;
   logic [PH_W-1:0]        ph_err;
   logic                   ph_valid;
   logic signed [FT_W-1:0] f_term;

   always_comb begin
      if (host_spd_i)      mode = MODE_HOST;
      else if (!freq_en_i) mode = MODE_PHASE;
      else if (xfreq_en_i) mode = MODE_XFREQ;
      else                 mode = MODE_FREQ;
   end

   tsp_phase_meter #(.PH_W(PH_W)) u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_tick  (ref_tick_i),
      .frame_stb (frame_stb_i),
      .ph_err    (ph_err),
      .ph_valid  (ph_valid)
   );

   tsp_freq_region #(
      .CNT_W   (CNT_W),
      .NOM_CNT (NOM_CNT),
      .F_SHIFT (F_SHIFT)
   ) u_freq (
      .bit_cnt (bit_cnt_i),
      .mode    (mode),
      .region  (region),
      .f_term  (f_term)
   );

   tsp_duty_calc #(
      .PH_W     (PH_W),
      .PH_SHIFT (PH_SHIFT),
      .FT_W     (FT_W)
   ) u_duty (
      .clk       (clk),
      .rst_n     (rst_n),
      .ref_tick  (ref_tick_i),
      .mode      (mode),
      .ph_err    (ph_err),
      .ph_valid  (ph_valid),
      .f_term    (f_term),
      .host_duty (host_duty_i),
      .duty_q    (duty_o),
      .miss_q    (phase_miss_o)
   );

   tsp_pwm #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_pwm (
      .clk     (clk),
      .rst_n   (rst_n),
      .duty    (duty_o),
      .speed_o (speed_o)
   );

   // R5: full-weight band in tape frequency mode only beyond the upper edge
   a_r5_no_half_in_freq: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_FREQ) |-> (region != REG_HALF));

   // R4: phase-only and host modes never carry a frequency term
   a_r4_no_term_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_PHASE || mode == MODE_HOST) |-> (f_term == '0));

endmodule

// File: tb/tape_servo_pwm_tb.sv
module tape_servo_pwm_tb_top;

   localparam int PH_W     = 10;
   localparam int PH_SHIFT = 1;
   localparam int CNT_W    = 12;
   localparam int NOM      = 2048;
   localparam int F_SHIFT  = 1;
   localparam int WIN      = 1 << PH_W;
   localparam int TH_HI    = (NOM * 6) / 100;
   localparam int TH_LO    = (NOM * 45) / 1000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             frame_stb = 1'b0;
   logic             ref_tick = 1'b0;
   logic [CNT_W-1:0] bit_cnt = CNT_W'(NOM);
   logic             fe = 1'b0, xe = 1'b0, hs = 1'b0;
   logic [7:0]       hduty = 8'd0;
   logic             speed;
   logic [7:0]       duty;
   logic             miss;

   int checks = 0;
   int errors = 0;
   bit running = 1'b0;

   always #10 clk = ~clk;

   tape_servo_pwm #(
      .PH_W(PH_W), .PH_SHIFT(PH_SHIFT), .CNT_W(CNT_W),
      .NOM_CNT(NOM), .F_SHIFT(F_SHIFT), .ACTIVE_HIGH(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_stb_i(frame_stb), .ref_tick_i(ref_tick),
      .bit_cnt_i(bit_cnt), .freq_en_i(fe), .xfreq_en_i(xe), .host_spd_i(hs),
      .host_duty_i(hduty), .speed_o(speed), .duty_o(duty), .phase_miss_o(miss)
   );

   // behavioural reference state
   int    m_since, m_cap, m_duty, m_pwm, m_act;
   bit    m_have, m_miss;
   string m_req = "R1";

   function automatic int fdiv(int a, int sh);
      int d = 1 << sh;
      if (a >= 0) return a / d;
      return -(((-a) + d - 1) / d);
   endfunction

   function automatic int mod256(int a);
      return ((a % 256) + 256) % 256;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_since = 0; m_cap = 0; m_have = 0;
         m_duty = 128; m_miss = 0; m_pwm = 0; m_act = 128;
      end else begin
         int cur, e, ph, dev, ad, f, s, nd;
         bit upd;
         cur = ref_tick ? 0 : m_since;
         if (m_pwm == 255) m_act = m_duty;
         m_pwm = (m_pwm + 1) % 256;
         if (ref_tick) begin
            e  = (m_cap >= WIN / 2) ? m_cap - WIN : m_cap;
            ph = mod256(128 + fdiv(e, PH_SHIFT));
            dev = int'(bit_cnt) - NOM;
            ad  = dev < 0 ? -dev : dev;
            f = 0;
            upd = m_have;
            if (hs) begin
               nd = hduty; upd = 1; m_req = "R7";
            end else if (!fe) begin
               nd = ph; m_req = (xe ? "R4" : "R2");
            end else begin
               if (ad > TH_HI) f = fdiv(-dev, F_SHIFT);
               else if (xe && ad > TH_LO) f = fdiv(-dev, F_SHIFT + 1);
               s = ph + f;
               nd = s < 0 ? 0 : (s > 255 ? 255 : s);
               m_req = (s < 0 || s > 255) ? "R12" : (xe ? "R6" : "R5");
            end
            if (!upd) m_req = "R8";
            if (upd) m_duty = nd;
            m_miss = !m_have;
            m_have = frame_stb;
            if (frame_stb) m_cap = 0;
         end else if (frame_stb && !m_have) begin
            m_have = 1; m_cap = cur;
         end
         m_since = ref_tick ? 1 : (m_since + 1) % WIN;
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (running) begin
         chk(m_req, duty, m_duty);
         chk("R10", speed, (m_pwm < m_act) ? 1 : 0);
         chk("R8", miss, m_miss);
      end
   end

   // one window: ref tick at k==0; strobes at off/off2; settings apply at next tick
   task automatic window(int off, int off2, bit stb, int cnt,
                         bit f_en, bit x_en, bit h_en, int hd);
      for (int k = 0; k < WIN; k++) begin
         @(negedge clk);
         ref_tick  = (k == 0);
         frame_stb = stb && (k == off || k == off2);
         if (k == 1) begin
            bit_cnt = CNT_W'(cnt); fe = f_en; xe = x_en; hs = h_en; hduty = 8'(hd);
         end
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R1", duty, 128);
      chk("R1", miss, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", duty, 128);
      chk("R1", speed, 1);
      running = 1'b1;
      window(-1, -1, 0, NOM, 0, 0, 0, 0);           // prime
      window(10,   -1, 1, NOM, 0, 0, 0, 0);         // R2 late small: 133
      window(1014, -1, 1, NOM, 0, 0, 0, 0);         // R2 early small: 123
      window(210,  -1, 1, NOM, 0, 0, 0, 0);         // R2 upper end: 233
      window(814,  -1, 1, NOM, 0, 0, 0, 0);         // R2 lower end: 23
      window(300,  -1, 1, NOM, 0, 0, 0, 0);         // R3 wrap: 22
      window(700,  -1, 1, NOM, 0, 0, 0, 0);         // R3 wrap: 222
      window(0,    -1, 1, 1800, 0, 1, 0, 0);        // R4 xfreq alone ignored: 128
      window(20,   -1, 1, NOM + TH_HI, 1, 0, 0, 0); // R5 on edge: 138
      window(20,   -1, 1, NOM + TH_HI + 1, 1, 0, 0, 0); // R5 beyond: 76
      window(100,  -1, 1, NOM - 200, 1, 0, 0, 0);   // R12 high clamp: 255
      window(20,   -1, 1, NOM + TH_LO, 1, 1, 0, 0); // R6 inside: 138
      window(20,   -1, 1, NOM + TH_LO + 1, 1, 1, 0, 0); // R6 half: 114
      window(20,   -1, 1, NOM - TH_HI, 1, 1, 0, 0); // R6 half: 168
      window(20,   -1, 1, NOM - TH_HI - 1, 1, 1, 0, 0); // R6 full: 199
      window(900,  -1, 1, 2400, 1, 1, 0, 0);        // R12 low clamp: 0
      window(-1,   -1, 0, NOM, 1, 1, 1, 77);        // R7 host, no strobe: 77
      window(-1,   -1, 0, NOM, 0, 0, 0, 0);         // R8 hold 77, flag set
      window(50,  400, 1, NOM, 0, 0, 0, 0);         // R11 first strobe: 153
      window(-1,   -1, 0, NOM, 0, 0, 0, 0);         // flush
      @(negedge clk);
      chk("R9", duty, m_duty);
      running = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule